// File: doc/BRIEF.md
# Binary/BCD Add-Subtract Unit

This unit performs the add-with-carry and subtract-with-borrow operations of an 8-bit accumulator machine. A decimal-mode input chooses how the operands are treated. In binary mode they are plain two's-complement bytes. In decimal mode they are packed BCD: two digits per byte, and the raw binary result is then corrected one nibble at a time. The unit takes the accumulator, the memory operand, the incoming carry and the mode bit. It returns the result byte, the sign, overflow, zero and carry flags, and an indicator that the operation costs the sequencer one extra cycle.

The unit is meant to sit in the execute stage of a CPU datapath. The surrounding logic presents the operands together with a one-cycle `in_valid` strobe. One clock later the registered result and flags appear with `out_valid`. The registered outputs keep their values until the next strobe. Bytes that are not valid BCD are accepted in decimal mode. They give a well-defined result, but no digit check is made.

Top module: `bcd_adsub_unit`

## Requirements
- R1: In binary mode an add yields result = (acc + opnd + carry_in) mod 256, with flag_c equal to bit 8 of that 9-bit sum.
- R2: In binary mode flag_v is set exactly when both addends (for a subtract, the accumulator and the inverted operand) share a sign bit that differs from the result's bit 7.
- R3: In binary mode a subtract (op_sub=1) computes acc + (~opnd) + carry_in. flag_c=1 therefore means no borrow, and carry_in=0 subtracts one more.
- R4: In both modes flag_n equals result bit 7, and flag_z is 1 exactly when the result byte is 0x00.
- R5: A decimal add adds 6 to the raw 8-bit sum when its low nibble is above 9 or when bits 3:0 of the addends plus carry_in produced a carry.
- R6: A decimal add then adds 0x60 and sets flag_c when any of these holds: the raw sum carried out of bit 7, the +6 step carried out of bit 7, or the byte after the +6 step is above 0x99. Otherwise flag_c is 0.
- R7: A decimal subtract uses the same two tests. Here a borrow from bit 3 takes the place of the half carry, and a borrow from either the raw subtract or the −6 step takes the place of the carry. It subtracts 6 and then 0x60. flag_c is 1 unless the 0x60 step was applied.
- R8: In decimal mode flag_v is always 0.
- R9: out_valid is high in exactly the cycle after an in_valid strobe. With no strobe, result and flags keep their previous values.
- R10: extra_cycle is delivered with each result and is 1 exactly when that operation ran in decimal mode.
- R11: During and right after reset, out_valid, result, all flags and extra_cycle are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand strobe, one cycle per operation |
| op_sub | input | 1 | 0 = add with carry, 1 = subtract with borrow |
| dec_mode | input | 1 | 1 = packed BCD operation |
| acc | input | 8 | Accumulator operand |
| opnd | input | 8 | Memory operand |
| carry_in | input | 1 | Incoming carry (for subtract: 1 = no borrow) |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| result | output | 8 | Result byte |
| flag_n | output | 1 | Sign flag |
| flag_v | output | 1 | Overflow flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry / no-borrow flag |
| extra_cycle | output | 1 | Operation needs one more sequencer cycle |

## Verification
There is no state beyond the output register, so any fault in the correction logic shows up at the ports on the very next cycle after the strobe. It appears as a wrong result digit, or as a carry that disagrees with the decimal over- or underflow. A mis-selected nibble test only shows for operand pairs that sit at the edge of a test: a low digit of exactly 9 or 10, a half carry that leaves a digit of 0 to 5, and sums of exactly 0x99 or 0x9A. The directed cases aim at those edges and a random sweep covers the rest. A register that fails to hold would corrupt the outputs in the idle cycles that follow a result, so the bench checks those cycles as well.

// File: rtl/bcd_adsub_pkg.sv
package bcd_adsub_pkg;

    localparam int DATA_W   = 8;
    localparam int NIB_W    = DATA_W / 2;
    localparam int DIGIT_MAX = 9;
    localparam int LO_FIX   = 6;
    localparam int HI_FIX   = LO_FIX << NIB_W;
    localparam int BYTE_MAX = (DIGIT_MAX << NIB_W) | DIGIT_MAX;

    typedef logic [DATA_W-1:0] byte_t;

    typedef struct packed {
        logic  valid;
        byte_t res;
        logic  n;
        logic  v;
        logic  z;
        logic  c;
        logic  extra;
    } adsub_state_t;

endpackage

// File: rtl/bcd_adsub_binary.sv
module bcd_adsub_binary
    import bcd_adsub_pkg::*;
(
    input  byte_t a,
    input  byte_t m,
    input  logic  cin,
    input  logic  sub,
    output byte_t sum,
    output logic  cout,
    output logic  half,
    output logic  ovf
);
    byte_t             m_eff;
    logic [DATA_W:0]   wide;
    logic [NIB_W:0]    low;

    always_comb begin
        m_eff = sub ? ~m : m;
        wide  = {1'b0, a} + {1'b0, m_eff} + {{DATA_W{1'b0}}, cin};
        low   = {1'b0, a[NIB_W-1:0]} + {1'b0, m_eff[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin};
        sum   = wide[DATA_W-1:0];
        cout  = wide[DATA_W];
        half  = low[NIB_W];
        ovf   = (a[DATA_W-1] == m_eff[DATA_W-1]) && (sum[DATA_W-1] != a[DATA_W-1]);
    end
endmodule

// File: rtl/bcd_adsub_adjust.sv
module bcd_adsub_adjust
    import bcd_adsub_pkg::*;
(
    input  byte_t raw,
    input  logic  raw_cout,
    input  logic  raw_half,
    input  logic  sub,
    output byte_t adj,
    output logic  c_out
);
    localparam byte_t LO_K  = byte_t'(LO_FIX);
    localparam byte_t HI_K  = byte_t'(HI_FIX);
    localparam byte_t TOP_K = byte_t'(BYTE_MAX);

    logic              nib_edge;
    logic              lo_need;
    logic              hi_need;
    logic              rim;
    logic [DATA_W:0]   lo_step;
    byte_t             mid;

    always_comb begin
        // in subtract mode the adder's carries mean "no borrow"
        nib_edge = sub ? ~raw_half : raw_half;
        lo_need  = (raw[NIB_W-1:0] > NIB_W'(DIGIT_MAX)) || nib_edge;
        if (sub)
            lo_step = {1'b0, raw} - {1'b0, LO_K};
        else
            lo_step = {1'b0, raw} + {1'b0, LO_K};
        mid      = lo_need ? lo_step[DATA_W-1:0] : raw;
        rim      = (sub ? ~raw_cout : raw_cout) || (lo_need && lo_step[DATA_W]);
        hi_need  = rim || (mid > TOP_K);
        if (!hi_need)
            adj = mid;
        else if (sub)
            adj = mid - HI_K;
        else
            adj = mid + HI_K;
        c_out    = sub ? ~hi_need : hi_need;
    end
endmodule

// File: rtl/bcd_adsub_unit.sv
module bcd_adsub_unit
    import bcd_adsub_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic        op_sub,
    input  logic        dec_mode,
    input  logic [7:0]  acc,
    input  logic [7:0]  opnd,
    input  logic        carry_in,
    output logic        out_valid,
    output logic [7:0]  result,
    output logic        flag_n,
    output logic        flag_v,
    output logic        flag_z,
    output logic        flag_c,
    output logic        extra_cycle
);
    byte_t        bin_sum;
    logic         bin_cout;
    logic         bin_half;
    logic         bin_ovf;
    byte_t        dec_sum;
    logic         dec_c;
    adsub_state_t st_d;
    adsub_state_t st_q;

    bcd_adsub_binary u_bin (
        .a    (acc),
        .m    (opnd),
        .cin  (carry_in),
        .sub  (op_sub),
        .sum  (bin_sum),
        .cout (bin_cout),
        .half (bin_half),
        .ovf  (bin_ovf)
    );

    bcd_adsub_adjust u_adj (
        .raw      (bin_sum),
        .raw_cout (bin_cout),
        .raw_half (bin_half),
        .sub      (op_sub),
        .adj      (dec_sum),
        .c_out    (dec_c)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.res   = dec_mode ? dec_sum : bin_sum;
            st_d.c     = dec_mode ? dec_c   : bin_cout;
            st_d.v     = dec_mode ? 1'b0    : bin_ovf;
            st_d.n     = st_d.res[DATA_W-1];
            st_d.z     = (st_d.res == '0);
            st_d.extra = dec_mode;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign out_valid   = st_q.valid;
    assign result      = st_q.res;
    assign flag_n      = st_q.n;
    assign flag_v      = st_q.v;
    assign flag_z      = st_q.z;
    assign flag_c      = st_q.c;
    assign extra_cycle = st_q.extra;

endmodule

// File: rtl/bcd_adsub_chk.sv
module bcd_adsub_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       op_sub,
    input logic       dec_mode,
    input logic [7:0] acc,
    input logic [7:0] opnd,
    input logic       carry_in,
    input logic       out_valid,
    input logic [7:0] result,
    input logic       flag_n,
    input logic       flag_v,
    input logic       flag_z,
    input logic       flag_c,
    input logic       extra_cycle
);
    // R9
    strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R9
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R9
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(flag_c) && $stable(flag_z)));
    // R4
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (flag_z == (result == 8'h00)) && (flag_n == result[7]));
    // R8
    no_dec_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && extra_cycle) |-> !flag_v);
    // R10
    extra_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (extra_cycle == $past(dec_mode)));
    // R1
    bin_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !dec_mode && !op_sub) |=>
        ({flag_c, result} == ($past({1'b0, acc}) + $past({1'b0, opnd}) + {8'h00, $past(carry_in)})));
    // R7
    dec_self_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dec_mode && op_sub && carry_in && (acc == opnd)) |=>
        (result == 8'h00 && flag_c));
endmodule

bind bcd_adsub_unit bcd_adsub_chk u_chk (.*);

// File: tb/bcd_adsub_unit_bench.sv
module bcd_adsub_unit_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       op_sub = 1'b0;
    logic       dec_mode = 1'b0;
    logic [7:0] acc = '0;
    logic [7:0] opnd = '0;
    logic       carry_in = 1'b0;
    logic       out_valid;
    logic [7:0] result;
    logic       flag_n, flag_v, flag_z, flag_c, extra_cycle;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] last_res = 8'h00;
    logic       finished = 1'b0;

    typedef struct {
        logic [7:0] res;
        logic n, v, z, c, x;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    bcd_adsub_unit u_bcd_adsub_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sub(op_sub),
        .dec_mode(dec_mode), .acc(acc), .opnd(opnd), .carry_in(carry_in),
        .out_valid(out_valid), .result(result), .flag_n(flag_n),
        .flag_v(flag_v), .flag_z(flag_z), .flag_c(flag_c),
        .extra_cycle(extra_cycle)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic exp_t model(input logic s, input logic d, input int a,
                                   input int m, input int c, input string tag);
        exp_t e;
        int r, t, mi;
        logic cy, hi, lo, edge_c;
        e.tag = tag;
        e.x   = d;
        e.v   = 1'b0;
        if (!d) begin
            mi = s ? (255 - m) : m;
            t  = a + mi + c;
            r  = t % 256;
            cy = (t > 255);
            e.v = (((a ^ r) & (mi ^ r) & 128) != 0);
        end else if (!s) begin
            t  = a + m + c;
            r  = t % 256;
            lo = ((r % 16) > 9) || (((a % 16) + (m % 16) + c) > 15);
            edge_c = 1'b0;
            if (lo) begin
                r = r + 6;
                edge_c = (r > 255);
                r = r % 256;
            end
            hi = (t > 255) || edge_c || (r > 153);
            if (hi) r = (r + 96) % 256;
            cy = hi;
        end else begin
            t  = a - m - (1 - c);
            r  = (t + 256) % 256;
            lo = ((r % 16) > 9) || (((a % 16) - (m % 16) - (1 - c)) < 0);
            edge_c = 1'b0;
            if (lo) begin
                edge_c = (r < 6);
                r = (r + 250) % 256;
            end
            hi = (t < 0) || edge_c || (r > 153);
            if (hi) r = (r + 160) % 256;
            cy = !hi;
        end
        e.res = 8'(r);
        e.c = cy;
        e.n = e.res[7];
        e.z = (e.res == 8'h00);
        return e;
    endfunction

    task automatic drive(input logic s, input logic d, input int a, input int m,
                         input int c, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        op_sub = s; dec_mode = d;
        acc = 8'(a); opnd = 8'(m); carry_in = c[0];
        sb.push_back(model(s, d, a, m, c, tag));
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            acc = ~acc; opnd = opnd + 8'd3; dec_mode = ~dec_mode;
        end
    endtask

    // monitor: compares each result, and checks the hold behaviour between results
    initial begin
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            #1;
            if (out_valid) begin
                exp_t e;
                if (sb.size() == 0) begin
                    check("R9 unexpected out_valid", 1, 0);
                end else begin
                    e = sb.pop_front();
                    check({e.tag, " result"}, result, e.res);
                    check({e.tag, " R4 n/z"}, {flag_n, flag_z}, {e.n, e.z});
                    check({e.tag, " R2 R8 v"}, flag_v, e.v);
                    check({e.tag, " c"}, flag_c, e.c);
                    check({e.tag, " R10 extra"}, extra_cycle, e.x);
                    last_res = e.res;
                end
            end else begin
                check("R9 hold while idle", result, last_res);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 reset outputs", {out_valid, result, flag_n, flag_v, flag_z, flag_c, extra_cycle}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 after reset", {out_valid, result, extra_cycle}, 0);

        drive(0, 0, 8'h50, 8'h50, 0, "R1 R2 add ovf");
        drive(0, 0, 8'hFF, 8'h00, 1, "R1 add carry zero");
        drive(0, 0, 8'h12, 8'h34, 1, "R1 add cin");
        drive(1, 0, 8'h50, 8'hB0, 1, "R3 R2 sub ovf");
        drive(1, 0, 8'h05, 8'h05, 1, "R3 sub equal");
        drive(1, 0, 8'h05, 8'h05, 0, "R3 sub borrow in");
        idle(2);
        drive(0, 1, 8'h09, 8'h01, 0, "R5 dec lo digit");
        drive(0, 1, 8'h49, 8'h49, 0, "R5 dec half carry");
        drive(0, 1, 8'h58, 8'h46, 1, "R6 dec both steps");
        drive(0, 1, 8'h99, 8'h01, 0, "R6 dec wrap zero");
        drive(0, 1, 8'h90, 8'h90, 0, "R6 dec raw carry");
        drive(0, 1, 8'h45, 8'h54, 0, "R6 dec exact 99");
        drive(1, 1, 8'h10, 8'h01, 1, "R7 dec sub lo");
        drive(1, 1, 8'h00, 8'h01, 1, "R7 dec sub under");
        drive(1, 1, 8'h12, 8'h21, 1, "R7 dec sub neg");
        drive(1, 1, 8'h50, 8'h25, 0, "R7 dec sub borrow in");
        drive(0, 1, 8'hFA, 8'h0F, 0, "R6 dec non-bcd");
        idle(3);
        for (int i = 0; i < 400; i++) begin
            int a = $urandom_range(0, 255);
            int m = $urandom_range(0, 255);
            int c = $urandom_range(0, 1);
            logic s = 1'($urandom_range(0, 1));
            logic d = 1'($urandom_range(0, 1));
            drive(s, d, a, m, c, d ? (s ? "R7 sweep" : "R5 R6 sweep") : (s ? "R3 sweep" : "R1 sweep"));
            if ((i % 7) == 0) idle(1 + (i % 3));
        end
        idle(4);
        check("R9 all results seen", sb.size(), 0);
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule